// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital heart of a 256-step digitally controlled resistor. Three slow, asynchronous control pins come in from a board-level controller. `sel_n` is an active-low chip select. `inc_n` is a step strobe that acts on its falling edge. `dir_up` sets the direction. A system clock brings all three through two-flop synchronizers. An 8-bit tap register, whose value is the wiper code handed to the resistor ladder, moves one step on each qualifying strobe edge and clamps at both ends of the range.

One saved word models the nonvolatile cell. It survives the synchronous reset, which stands in for power-on, and every reset copies it into the tap register. Releasing chip select while the strobe is high saves the current tap value. The store is modelled as a busy period of a parameterized length, and the saved word changes only when that period ends. Releasing chip select while the strobe is low just returns the block to standby. An optional monitor measures strobe, select and direction timing in clock cycles and pulses a flag when a minimum is broken.

Top module: `updn_wiper_ctrl`

## Requirements
- R1: On reset the wiper code takes the saved word. Before any store has happened, the saved word holds the parameter `DEFAULT_CODE`, which defaults to 128 (0x80).
- R2: During an armed selection (R7), each falling edge of `inc_n` moves the wiper code by exactly one. It moves up when `dir_up` = 1 and down when `dir_up` = 0, with `dir_up` taken at the synchronized falling edge. The rising edge of `inc_n` moves nothing.
- R3: Steps clamp at the ends of the range. A down step at 0 leaves the code at 0, an up step at 255 leaves it at 255, and the code never wraps.
- R4: When `sel_n` rises at the end of an armed selection while `inc_n` is high, `store_busy` goes high for exactly `STORE_CYCLES` clock cycles. When it falls, the saved word takes the wiper code that was current at the release, which a later reset makes visible.
- R5: When `sel_n` rises while `inc_n` is low, `store_busy` stays low and the saved word is left unchanged.
- R6: While `sel_n` is high, activity on `inc_n` and `dir_up` leaves the wiper code unchanged.
- R7: A selection is armed only if the falling edge of `sel_n` arrives while `store_busy` is low. A selection that begins during the busy period stays inert until `sel_n` rises again: its strobe edges move nothing and its release starts no store.
- R8: `timing_err` pulses for one cycle when, during a selection, a synchronized `inc_n` edge breaks one of these minimums: the low period (`MIN_INC_LOW`), the high period (`MIN_INC_HIGH`), the fall-to-fall period (`MIN_INC_PERIOD`), the select-to-strobe setup (`MIN_SEL_SETUP`), or the direction setup and hold around the falling edge (`MIN_DIR_SETUP`, `MIN_DIR_HOLD`). It stays low for sequences that meet all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on stand-in) |
| sel_n | input | 1 | Asynchronous chip select, active low |
| inc_n | input | 1 | Asynchronous step strobe, acts on its falling edge |
| dir_up | input | 1 | Asynchronous direction: 1 steps up, 0 steps down |
| wiper_code | output | TAP_W | Current tap register value |
| store_busy | output | 1 | High while a save is in progress |
| timing_err | output | 1 | One-cycle pulse on a timing violation |

## Verification
Several properties are checked on every cycle. The wiper never moves by more than one code per clock, never wraps between 0 and 255, and stays still when no armed selection exists or a store is busy. The busy period always lasts exactly `STORE_CYCLES` cycles. The content of the saved word, the recall on reset, the choice between store and no-store on release, and the detection of each timing minimum can only be shown by the bench scenarios. Those scenarios sweep the full code range in both directions and then observe the saved word through reset.

// File: rtl/updn_pkg.sv
// Shared types for the up/down wiper controller.
// Assumes: the three control levels travel together as one packed word.
package updn_pkg;

    // Synchronized control levels, in pin polarity
    typedef struct packed {
        logic sel_n;
        logic inc_n;
        logic dir_up;
    } ctl_lvl_t;

    // One-cycle events derived from the synchronized levels
    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic inc_fall;
        logic inc_rise;
        logic dir_chg;
    } ctl_evt_t;

    // Idle pin state: deselected, strobe high, direction down
    localparam ctl_lvl_t CTL_IDLE = '{sel_n: 1'b1, inc_n: 1'b1, dir_up: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/updn_sync.sv
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent slow level; STAGES >= 2.
module updn_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift the levels one stage deeper each clock
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q[g] <= RST_VAL;
                end else begin
                    if (g == 0) pipe_q[g] <= async_in;
                    else        pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/updn_session.sv
// Selection session and tap register.
// Derives edge events from the synchronized levels, arms a selection that
// begins outside a store, steps the saturating tap register and requests
// a store on a qualifying release. Assumes: nv_word is stable during reset.
module updn_session
    import updn_pkg::*;
#(
    parameter int TAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_lvl_t         lvl,
    input  logic             busy,
    input  logic [TAP_W-1:0] nv_word,
    output ctl_evt_t         evt,
    output logic             armed,
    output logic             store_start,
    output logic [TAP_W-1:0] tap
);

    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
    localparam logic [TAP_W-1:0] TAP_MIN = '0;

    ctl_lvl_t         prev_q;
    logic             arm_q;
    logic [TAP_W-1:0] tap_q;
    logic             step_up;
    logic             step_dn;

    // Purpose: hold the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= CTL_IDLE;
        else        prev_q <= lvl;
    end

    // Purpose: form one-cycle edge events
    always_comb begin
        evt.sel_fall = prev_q.sel_n & ~lvl.sel_n;
        evt.sel_rise = ~prev_q.sel_n & lvl.sel_n;
        evt.inc_fall = prev_q.inc_n & ~lvl.inc_n;
        evt.inc_rise = ~prev_q.inc_n & lvl.inc_n;
        evt.dir_chg  = prev_q.dir_up ^ lvl.dir_up;
    end

    // Purpose: arm a selection only when it starts outside a store
    always_ff @(posedge clk) begin
        if (!rst_n)                      arm_q <= 1'b0;
        else if (lvl.sel_n)              arm_q <= 1'b0;
        else if (evt.sel_fall && !busy)  arm_q <= 1'b1;
    end

    // Purpose: decode step requests with the direction seen at the edge
    always_comb begin
        step_up = arm_q && !busy && !lvl.sel_n && evt.inc_fall &&  lvl.dir_up;
        step_dn = arm_q && !busy && !lvl.sel_n && evt.inc_fall && !lvl.dir_up;
    end

    // Purpose: recall on reset, otherwise step with clamping at both ends
    always_ff @(posedge clk) begin
        if (!rst_n)                            tap_q <= nv_word;
        else if (step_up && tap_q != TAP_MAX)  tap_q <= tap_q + 1'b1;
        else if (step_dn && tap_q != TAP_MIN)  tap_q <= tap_q - 1'b1;
    end

    assign store_start = arm_q && evt.sel_rise && lvl.inc_n;
    assign armed       = arm_q;
    assign tap         = tap_q;

endmodule

// File: rtl/updn_nv_store.sv
// Model of the single nonvolatile word with a busy period.
// The word keeps its value through reset and powers up at DEFAULT_CODE.
// A store latches the data, stays busy for STORE_CYCLES cycles and
// commits the word on the last one. Assumes: STORE_CYCLES >= 1.
module updn_nv_store #(
    parameter int TAP_W        = 8,
    parameter int DEFAULT_CODE = 128,
    parameter int STORE_CYCLES = 3_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAP_W-1:0] wdata,
    output logic [TAP_W-1:0] nv_word,
    output logic             busy
);

    localparam int CW = $clog2(STORE_CYCLES) + 1;
    localparam logic [CW-1:0] LOAD = CW'(STORE_CYCLES - 1);

    logic [TAP_W-1:0] nv_q = TAP_W'(DEFAULT_CODE);
    logic [TAP_W-1:0] pend_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;

    // Purpose: run the busy countdown; reset abandons a store in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= LOAD;
                pend_q <= wdata;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: commit the word once, in the last busy cycle; never reset
    always_ff @(posedge clk) begin
        if (rst_n && busy_q && cnt_q == '0) nv_q <= pend_q;
    end

    assign nv_word = nv_q;
    assign busy    = busy_q;

endmodule

// File: rtl/updn_timing_mon.sv
// Cycle-based timing monitor for the control pins.
// Counts cycles since the last strobe edge, the last strobe fall, the last
// select fall and the last direction change, and flags minimum violations
// while selected. Assumes: every minimum is at least 1.
module updn_timing_mon
    import updn_pkg::*;
#(
    parameter int MIN_INC_LOW    = 50,
    parameter int MIN_INC_HIGH   = 50,
    parameter int MIN_INC_PERIOD = 200,
    parameter int MIN_SEL_SETUP  = 20,
    parameter int MIN_DIR_SETUP  = 10,
    parameter int MIN_DIR_HOLD   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic selected,
    input  logic sel_fall,
    input  logic inc_fall,
    input  logic inc_rise,
    input  logic dir_chg,
    output logic timing_err
);

    localparam int MAXP = max2(max2(max2(MIN_INC_LOW, MIN_INC_HIGH), max2(MIN_INC_PERIOD, MIN_SEL_SETUP)),
                               max2(MIN_DIR_SETUP, MIN_DIR_HOLD));
    localparam int CW = $clog2(MAXP + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [CW-1:0] LIM_LOW  = CW'(MIN_INC_LOW - 1);
    localparam logic [CW-1:0] LIM_HIGH = CW'(MIN_INC_HIGH - 1);
    localparam logic [CW-1:0] LIM_PER  = CW'(MIN_INC_PERIOD - 1);
    localparam logic [CW-1:0] LIM_SEL  = CW'(MIN_SEL_SETUP - 1);
    localparam logic [CW-1:0] LIM_DSU  = CW'(MIN_DIR_SETUP - 1);
    localparam logic [CW-1:0] LIM_DH   = CW'(MIN_DIR_HOLD - 1);

    logic [CW-1:0] edge_q, fall_q, sel_q, dir_q;
    logic          viol;
    logic          err_q;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
        return (c == CMAX) ? c : c + 1'b1;
    endfunction

    // Purpose: saturating elapsed-cycle counters, cleared by their events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= CMAX;
            fall_q <= CMAX;
            sel_q  <= CMAX;
            dir_q  <= CMAX;
        end else begin
            edge_q <= (inc_fall || inc_rise) ? '0 : bump(edge_q);
            fall_q <= inc_fall ? '0 : bump(fall_q);
            sel_q  <= sel_fall ? '0 : bump(sel_q);
            dir_q  <= dir_chg  ? '0 : bump(dir_q);
        end
    end

    // Purpose: compare each elapsed count with its minimum at the event
    always_comb begin
        viol = 1'b0;
        if (selected) begin
            if (inc_rise && edge_q < LIM_LOW)                viol = 1'b1;
            if (inc_fall && edge_q < LIM_HIGH)               viol = 1'b1;
            if (inc_fall && fall_q < LIM_PER)                viol = 1'b1;
            if (inc_fall && (sel_fall || sel_q < LIM_SEL))   viol = 1'b1;
            if (inc_fall && (dir_chg || dir_q < LIM_DSU))    viol = 1'b1;
            if (dir_chg && !inc_fall && fall_q < LIM_DH)     viol = 1'b1;
        end
    end

    // Purpose: register the violation into a one-cycle flag
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= viol;
    end

    assign timing_err = err_q;

endmodule

// File: rtl/updn_wiper_ctrl.sv
// Top of the up/down wiper position controller.
// Synchronizes the three control pins, runs the selection session and tap
// register, models the saved word and, when enabled, the timing monitor.
// Assumes: rst_n is held low for at least two clocks at power-on.
module updn_wiper_ctrl
    import updn_pkg::*;
#(
    parameter int TAP_W           = 8,
    parameter int DEFAULT_CODE    = 128,
    parameter int STORE_CYCLES    = 3_000_000,
    parameter int SYNC_STAGES     = 2,
    parameter bit TIMING_CHECK_EN = 1'b1,
    parameter int MIN_INC_LOW     = 50,
    parameter int MIN_INC_HIGH    = 50,
    parameter int MIN_INC_PERIOD  = 200,
    parameter int MIN_SEL_SETUP   = 20,
    parameter int MIN_DIR_SETUP   = 10,
    parameter int MIN_DIR_HOLD    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             inc_n,
    input  logic             dir_up,
    output logic [TAP_W-1:0] wiper_code,
    output logic             store_busy,
    output logic             timing_err
);

    localparam int LVL_W = $bits(ctl_lvl_t);

    ctl_lvl_t         pins;
    ctl_lvl_t         lvl;
    logic [LVL_W-1:0] lvl_raw;
    ctl_evt_t         evt;
    logic             armed;
    logic             store_start;
    logic             busy;
    logic [TAP_W-1:0] nv_word;
    logic [TAP_W-1:0] tap;

    assign pins = '{sel_n: sel_n, inc_n: inc_n, dir_up: dir_up};

    updn_sync #(
        .W       (LVL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LVL_W'(CTL_IDLE))
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (lvl_raw)
    );

    assign lvl = ctl_lvl_t'(lvl_raw);

    updn_session #(
        .TAP_W (TAP_W)
    ) u_session (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl         (lvl),
        .busy        (busy),
        .nv_word     (nv_word),
        .evt         (evt),
        .armed       (armed),
        .store_start (store_start),
        .tap         (tap)
    );

    updn_nv_store #(
        .TAP_W        (TAP_W),
        .DEFAULT_CODE (DEFAULT_CODE),
        .STORE_CYCLES (STORE_CYCLES)
    ) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (store_start),
        .wdata   (tap),
        .nv_word (nv_word),
        .busy    (busy)
    );

    generate
        if (TIMING_CHECK_EN) begin : g_tmon
            updn_timing_mon #(
                .MIN_INC_LOW    (MIN_INC_LOW),
                .MIN_INC_HIGH   (MIN_INC_HIGH),
                .MIN_INC_PERIOD (MIN_INC_PERIOD),
                .MIN_SEL_SETUP  (MIN_SEL_SETUP),
                .MIN_DIR_SETUP  (MIN_DIR_SETUP),
                .MIN_DIR_HOLD   (MIN_DIR_HOLD)
            ) u_tmon (
                .clk        (clk),
                .rst_n      (rst_n),
                .selected   (~lvl.sel_n),
                .sel_fall   (evt.sel_fall),
                .inc_fall   (evt.inc_fall),
                .inc_rise   (evt.inc_rise),
                .dir_chg    (evt.dir_chg),
                .timing_err (timing_err)
            );
        end else begin : g_no_tmon
            assign timing_err = 1'b0;
        end
    endgenerate

    assign wiper_code = tap;
    assign store_busy = busy;

endmodule

// File: rtl/updn_wiper_ctrl_chk.sv
// Property checker for the wiper controller, bound to the top module.
// Keeps its own busy-length counter so the window is not unrolled.
module updn_wiper_ctrl_chk #(
    parameter int TAP_W        = 8,
    parameter int STORE_CYCLES = 3_000_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] wiper_code,
    input logic             store_busy,
    input logic             armed
);

    localparam int CW = $clog2(STORE_CYCLES + 1) + 1;
    localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

    logic [CW-1:0] busy_cnt;

    // Purpose: count the cycles of the current busy period
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (store_busy) busy_cnt <= busy_cnt + 1'b1;
        else                 busy_cnt <= '0;
    end

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wiper_code != $past(wiper_code)) |->
        ({1'b0, wiper_code} == {1'b0, $past(wiper_code)} + 1'b1 ||
         {1'b0, wiper_code} + 1'b1 == {1'b0, $past(wiper_code)}));

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wiper_code) == TOP) |-> wiper_code != '0);

    assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wiper_code) == '0) |-> wiper_code != TOP);

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(store_busy)) |-> $past(busy_cnt) == CW'(STORE_CYCLES - 1));

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy |-> busy_cnt < CW'(STORE_CYCLES));

    assert_idle_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(armed)) |-> $stable(wiper_code));

    assert_busy_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(store_busy)) |-> $stable(wiper_code));

    assert_no_arm_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy |-> !armed);

endmodule

bind updn_wiper_ctrl updn_wiper_ctrl_chk #(
    .TAP_W        (TAP_W),
    .STORE_CYCLES (STORE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wiper_code (wiper_code),
    .store_busy (store_busy),
    .armed      (armed)
);

// File: tb/updn_wiper_ctrl_bench.sv
// Self-checking bench: full-range sweeps, store/no-store releases, busy
// lockout, standby and timing-monitor cases on a short-timing configuration.
module updn_wiper_ctrl_bench;

    localparam int TAP_W  = 8;
    localparam int STORE  = 120;
    localparam int TOPV   = 255;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sel_n;
    logic             inc_n;
    logic             dir_up;
    logic [TAP_W-1:0] wiper_code;
    logic             store_busy;
    logic             timing_err;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_tap;
    int exp_nv;
    int err_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updn_wiper_ctrl #(
        .TAP_W          (TAP_W),
        .DEFAULT_CODE   (128),
        .STORE_CYCLES   (STORE),
        .SYNC_STAGES    (2),
        .TIMING_CHECK_EN(1'b1),
        .MIN_INC_LOW    (4),
        .MIN_INC_HIGH   (4),
        .MIN_INC_PERIOD (10),
        .MIN_SEL_SETUP  (3),
        .MIN_DIR_SETUP  (2),
        .MIN_DIR_HOLD   (2)
    ) u_updn_wiper_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .inc_n      (inc_n),
        .dir_up     (dir_up),
        .wiper_code (wiper_code),
        .store_busy (store_busy),
        .timing_err (timing_err)
    );

    // Count timing-flag pulses seen at the outputs
    always @(negedge clk) if (timing_err === 1'b1) err_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // One conforming strobe pulse; 'live' means the step should take effect
    task automatic pulse(input logic up, input bit live);
        dir_up = up;
        idle(4);
        inc_n = 1'b0;
        idle(6);
        inc_n = 1'b1;
        idle(6);
        if (live) begin
            if (up) exp_tap = (exp_tap == TOPV) ? TOPV : exp_tap + 1;
            else    exp_tap = (exp_tap == 0) ? 0 : exp_tap - 1;
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        exp_tap = exp_nv;
    endtask

    task automatic select;
        sel_n = 1'b0;
        idle(6);
    endtask

    // Count busy cycles over a window
    task automatic busy_len(input int win, output int len);
        len = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (store_busy) len++;
        end
    endtask

    initial begin
        int len;
        int e0;
        rst_n = 1'b0; sel_n = 1'b1; inc_n = 1'b1; dir_up = 1'b0;
        exp_nv = 128;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        exp_tap = exp_nv;

        // R1: power-on value and idle outputs
        chk("R1 reset code", int'(wiper_code), 128);
        chk("R1 reset busy", int'(store_busy), 0);
        chk("R1 reset flag", int'(timing_err), 0);

        // R2/R3: sweep up past the top, then down past the bottom
        select();
        for (int i = 0; i < 130; i++) begin
            pulse(1'b1, 1'b1);
            chk((exp_tap == TOPV) ? "R3 top clamp" : "R2 step up", int'(wiper_code), exp_tap);
        end
        for (int i = 0; i < 260; i++) begin
            pulse(1'b0, 1'b1);
            chk((exp_tap == 0) ? "R3 bottom clamp" : "R2 step down", int'(wiper_code), exp_tap);
        end
        for (int i = 0; i < 37; i++) pulse(1'b1, 1'b1);
        chk("R2 climb to 37", int'(wiper_code), 37);
        chk("R8 no flag on clean timing", err_seen, 0);

        // R4: release with strobe high stores
        sel_n = 1'b1;
        busy_len(STORE + 40, len);
        exp_nv = exp_tap;
        chk("R4 busy length", len, STORE);
        do_reset();
        chk("R4 recall stored", int'(wiper_code), 37);

        // R5: release with strobe low does not store
        select();
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        inc_n = 1'b0;
        exp_tap = exp_tap + 1;
        idle(6);
        chk("R5 fall steps", int'(wiper_code), 43);
        sel_n = 1'b1;
        busy_len(STORE + 40, len);
        chk("R5 no busy", len, 0);
        chk("R5 code kept", int'(wiper_code), 43);
        inc_n = 1'b1;
        idle(4);
        do_reset();
        chk("R5 word unchanged", int'(wiper_code), 37);

        // R6: standby ignores strobe and direction
        for (int i = 0; i < 20; i++) begin
            dir_up = i[0];
            idle(3);
            inc_n = 1'b0;
            idle(5);
            inc_n = 1'b1;
            idle(5);
        end
        chk("R6 standby code", int'(wiper_code), 37);

        // R7: selection during busy stays inert
        select();
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1);
        chk("R7 pre-store code", int'(wiper_code), 40);
        sel_n = 1'b1;
        idle(5);
        exp_nv = exp_tap;
        chk("R7 busy started", int'(store_busy), 1);
        select();
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        chk("R7 still busy", int'(store_busy), 1);
        chk("R7 no step in busy", int'(wiper_code), 40);
        idle(STORE);
        chk("R7 busy ended", int'(store_busy), 0);
        pulse(1'b0, 1'b0);
        pulse(1'b0, 1'b0);
        chk("R7 inert after busy", int'(wiper_code), 40);
        sel_n = 1'b1;
        busy_len(STORE + 40, len);
        chk("R7 no store from inert", len, 0);
        do_reset();
        chk("R7 single store", int'(wiper_code), 40);

        // R8: short low period
        select();
        e0 = err_seen;
        dir_up = 1'b1;
        idle(4);
        inc_n = 1'b0;
        idle(1);
        inc_n = 1'b1;
        idle(12);
        exp_tap = exp_tap + 1;
        chk("R8 short low flagged", int'(err_seen > e0), 1);
        chk("R8 short low code", int'(wiper_code), exp_tap);

        // R8: direction changed at the falling edge
        e0 = err_seen;
        dir_up = 1'b0;
        inc_n = 1'b0;
        idle(6);
        inc_n = 1'b1;
        idle(12);
        exp_tap = exp_tap - 1;
        chk("R8 dir setup flagged", int'(err_seen > e0), 1);
        chk("R8 dir setup code", int'(wiper_code), exp_tap);

        // R8: strobe too soon after select (release first, wait out store)
        sel_n = 1'b1;
        exp_nv = exp_tap;
        idle(STORE + 20);
        e0 = err_seen;
        dir_up = 1'b1;
        idle(4);
        sel_n = 1'b0;
        idle(1);
        inc_n = 1'b0;
        idle(6);
        inc_n = 1'b1;
        idle(12);
        exp_tap = exp_tap + 1;
        chk("R8 select setup flagged", int'(err_seen > e0), 1);
        chk("R8 select setup code", int'(wiper_code), exp_tap);

        sel_n = 1'b1;
        idle(STORE + 20);
        done = 1'b1;
        report();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

endmodule